// File: doc/BRIEF.md
# Parameterised Floating-Point Format Converter

This block converts a binary floating-point operand from one format to another. Each side has its own exponent width and fraction width, so the same block narrows values (for example an 8-bit exponent with a 23-bit fraction down to a 6-bit exponent with an 18-bit fraction) or widens them. A word holds the sign in its most significant bit, then the biased exponent, then the fraction, with a sign of 1 meaning negative. For an exponent field of width e the bias is 2^(e-1)-1. A normal value carries an implied leading one ahead of its fraction bits.

The operand is first sorted into one of five classes: zero, denormal, normal, infinity or NaN. The exponent is then moved to the target bias and the significand is cut down or padded to the target fraction width. The value is rounded in one of four directions, chosen on every operand. Results too small for a normal number become denormals. When denormal support is switched off by parameter, those results become signed zeros instead. A result too large for the target format becomes infinity or the largest finite value, depending on the rounding direction. Each result is registered, so it appears one cycle after its operand together with the input class and four exception flags.

Top module: `fpcvt_top`

## Requirements
- R1: A normal operand whose value fits the target format converts with its sign kept. The target exponent is the input exponent minus the input bias plus the output bias, and the fraction is truncated or zero-padded on the right.
- R2: `class_o` reports the class of the input operand: 0 zero, 1 denormal, 2 normal, 3 infinity, 4 NaN.
- R3: Rounding mode 0 rounds to nearest. On an exact tie it rounds so that the kept fraction LSB is even.
- R4: Rounding mode 1 truncates toward zero. Mode 2 rounds toward positive infinity, and mode 3 rounds toward negative infinity.
- R5: If rounding carries out of the fraction, the fraction becomes zero and the exponent goes up by one.
- R6: A result whose biased exponent would reach all ones sets overflow and inexact. It becomes a signed infinity in mode 0, and in mode 2 for positive values or mode 3 for negative values. In every other case it becomes the largest finite value of the same sign.
- R7: With denormals enabled, a result below the normal range is produced as a denormal: exponent field 0, value 0.fraction × 2^(1-bias). Underflow is set when such a tiny result (judged before rounding) is inexact. A tiny result may round up to the smallest normal.
- R8: With denormals enabled, a denormal input (exponent 0, nonzero fraction) is normalized, so it converts exactly into a wider format.
- R9: A NaN input gives a NaN output with the same sign, an all-ones exponent and a fraction of only its MSB set. Invalid is set when the input fraction MSB is 0.
- R10: Zero and infinity inputs pass through with their sign and no flags raised.
- R11: With denormals disabled, an input whose exponent field is 0 is taken as a signed zero (class 0). A result below the normal range becomes a zero of the same sign, with underflow and inexact set.
- R12: Inexact is set exactly when nonzero bits are discarded by rounding (or on overflow or a flush). An exactly representable value raises no flag.
- R13: Each operand accepted with `valid_i` gives its result with `valid_o` on the following cycle. `valid_o` is low in any cycle not preceded by `valid_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operand present |
| rmode_i | input | 2 | Rounding direction: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| a_i | input | 1+EW_I+FW_I | Input word: sign, exponent, fraction |
| valid_o | output | 1 | Result present |
| z_o | output | 1+EW_O+FW_O | Converted word |
| class_o | output | 3 | Class of the input operand |
| ovf_o | output | 1 | Overflow |
| unf_o | output | 1 | Underflow |
| inx_o | output | 1 | Inexact |
| inv_o | output | 1 | Invalid (signalling NaN input) |

## Verification
The bench targets several rounding corner cases. Ties are placed on both even and odd kept LSBs, because a design that rounds half away from zero moves the even case up. Fractions of all ones must carry into the exponent; a design without that carry would wrap the fraction to zero at the old exponent. At the top of the range, an input one above the largest exponent is run through each rounding direction and both signs to tell infinity from the largest finite value. A value one rounding step below overflow is also used, so a design that checks overflow before rounding would miss the overflow. At the bottom of the range, the results probed are a value landing exactly on the denormal boundary, a tiny value that rounds up to the smallest normal, and values below the denormal range. Denormal inputs are widened so that a wrong leading-zero count shows up as a shifted exponent. A flush-to-zero instance checks that tiny values and zero-exponent inputs lose nothing but magnitude, and that the sign survives.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_SUB  = 3'd1,
    CL_NORM = 3'd2,
    CL_INF  = 3'd3,
    CL_NAN  = 3'd4
  } class_e;

  typedef struct packed {
    logic inv;
    logic ovf;
    logic unf;
    logic inx;
  } exc_t;
endpackage

// File: rtl/fpcvt_unpack.sv
module fpcvt_unpack
  import fpcvt_pkg::*;
#(
  parameter int EW_I      = 8,
  parameter int FW_I      = 23,
  parameter int EW_O      = 6,
  parameter bit DENORM_EN = 1'b1
) (
  input  logic [EW_I+FW_I:0] a_i,
  output logic               sign_o,
  output class_e             cls_o,
  output int                 texp_o,
  output logic [FW_I-1:0]    frac_o,
  output logic               snan_o
);
  localparam int BI = 2 ** (EW_I - 1) - 1;
  localparam int BO = 2 ** (EW_O - 1) - 1;

  logic [EW_I-1:0] e;
  logic [FW_I-1:0] f;
  int lz;

  assign sign_o = a_i[EW_I+FW_I];
  assign e      = a_i[FW_I +: EW_I];
  assign f      = a_i[FW_I-1:0];

  // leading zeros of the fraction; last hit from the bottom is the highest one
  always_comb begin
    lz = FW_I;
    for (int i = 0; i < FW_I; i++) begin
      if (f[i]) lz = FW_I - 1 - i;
    end
  end

  always_comb begin
    cls_o  = CL_NORM;
    texp_o = int'(e) - BI + BO;
    frac_o = f;
    snan_o = 1'b0;
    if (&e) begin
      cls_o  = (f != '0) ? CL_NAN : CL_INF;
      snan_o = (f != '0) && !f[FW_I-1];
    end else if (e == '0) begin
      if (f == '0 || !DENORM_EN) begin
        cls_o = CL_ZERO;
      end else begin
        cls_o  = CL_SUB;
        texp_o = BO - BI - lz;
        frac_o = f << (lz + 1);
      end
    end
  end
endmodule

// File: rtl/fpcvt_round.sv
module fpcvt_round
  import fpcvt_pkg::*;
#(
  parameter int FW_I      = 23,
  parameter int EW_O      = 6,
  parameter int FW_O      = 18,
  parameter bit DENORM_EN = 1'b1
) (
  input  logic               sign_i,
  input  class_e             cls_i,
  input  int                 texp_i,
  input  logic [FW_I-1:0]    frac_i,
  input  logic               snan_i,
  input  rmode_e             rmode_i,
  output logic [EW_O+FW_O:0] z_o,
  output exc_t               exc_o
);
  localparam int L      = FW_I + FW_O + 4;
  localparam int EMAX   = 2 ** EW_O - 1;
  localparam int SH_CAP = FW_O + 2;

  logic [L-1:0]    ext, shd, mask;
  logic [FW_O-1:0] fk;
  logic [FW_O+1:0] sum;
  logic            g, st, inc, tiny, to_inf;
  int              sh, ebase, eout;

  always_comb begin
    ext  = {1'b1, frac_i, {(FW_O + 3){1'b0}}};
    tiny = texp_i < 1;
    // beyond SH_CAP the whole significand is sticky, so the cap is exact
    sh   = tiny ? (((1 - texp_i) > SH_CAP) ? SH_CAP : (1 - texp_i)) : 0;
    shd  = ext >> sh;
    mask = ({{(L - 1){1'b0}}, 1'b1} << sh) - 1'b1;
    fk   = shd[L-2 -: FW_O];
    g    = shd[L-2-FW_O];
    st   = (|shd[L-3-FW_O:0]) | (|(ext & mask));
    unique case (rmode_i)
      RM_NEAR: inc = g & (st | fk[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = (g | st) & ~sign_i;
      default: inc = (g | st) & sign_i;
    endcase
    sum    = {1'b0, shd[L-1], fk} + (FW_O + 2)'(inc);
    ebase  = tiny ? 1 : texp_i;
    eout   = ebase - 1 + 2 * int'(sum[FW_O+1]) + int'(sum[FW_O]);
    to_inf = (rmode_i == RM_NEAR) || (rmode_i == RM_UP && !sign_i) ||
             (rmode_i == RM_DOWN && sign_i);
  end

  always_comb begin
    exc_o = '0;
    z_o   = {sign_i, {(EW_O + FW_O){1'b0}}};
    unique case (cls_i)
      CL_NAN: begin
        z_o       = {sign_i, {EW_O{1'b1}}, 1'b1, {(FW_O - 1){1'b0}}};
        exc_o.inv = snan_i;
      end
      CL_INF:  z_o = {sign_i, {EW_O{1'b1}}, {FW_O{1'b0}}};
      CL_ZERO: z_o = {sign_i, {(EW_O + FW_O){1'b0}}};
      default: begin
        if (tiny && !DENORM_EN) begin
          exc_o.unf = 1'b1;
          exc_o.inx = 1'b1;
        end else if (eout >= EMAX) begin
          exc_o.ovf = 1'b1;
          exc_o.inx = 1'b1;
          z_o = to_inf ? {sign_i, {EW_O{1'b1}}, {FW_O{1'b0}}}
                       : {sign_i, EW_O'(EMAX - 1), {FW_O{1'b1}}};
        end else begin
          z_o       = {sign_i, EW_O'(eout), sum[FW_O-1:0]};
          exc_o.inx = g | st;
          exc_o.unf = tiny & (g | st);
        end
      end
    endcase
  end
endmodule

// File: rtl/fpcvt_top.sv
module fpcvt_top
  import fpcvt_pkg::*;
#(
  parameter int EW_I      = 8,
  parameter int FW_I      = 23,
  parameter int EW_O      = 6,
  parameter int FW_O      = 18,
  parameter bit DENORM_EN = 1'b1,
  localparam int IW = 1 + EW_I + FW_I,
  localparam int OW = 1 + EW_O + FW_O
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [1:0]    rmode_i,
  input  logic [IW-1:0] a_i,
  output logic          valid_o,
  output logic [OW-1:0] z_o,
  output logic [2:0]    class_o,
  output logic          ovf_o,
  output logic          unf_o,
  output logic          inx_o,
  output logic          inv_o
);
  logic            sign, snan;
  class_e          cls;
  int              texp;
  logic [FW_I-1:0] frac;
  logic [OW-1:0]   z_d;
  exc_t            exc_d, exc_q;

  fpcvt_unpack #(
    .EW_I(EW_I), .FW_I(FW_I), .EW_O(EW_O), .DENORM_EN(DENORM_EN)
  ) u_unpack (
    .a_i(a_i), .sign_o(sign), .cls_o(cls), .texp_o(texp),
    .frac_o(frac), .snan_o(snan)
  );

  fpcvt_round #(
    .FW_I(FW_I), .EW_O(EW_O), .FW_O(FW_O), .DENORM_EN(DENORM_EN)
  ) u_round (
    .sign_i(sign), .cls_i(cls), .texp_i(texp), .frac_i(frac),
    .snan_i(snan), .rmode_i(rmode_e'(rmode_i)), .z_o(z_d), .exc_o(exc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      z_o     <= '0;
      class_o <= '0;
      exc_q   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        z_o     <= z_d;
        class_o <= cls;
        exc_q   <= exc_d;
      end
    end
  end

  assign inv_o = exc_q.inv;
  assign ovf_o = exc_q.ovf;
  assign unf_o = exc_q.unf;
  assign inx_o = exc_q.inx;
endmodule

// File: rtl/fpcvt_chk.sv
module fpcvt_chk #(
  parameter int EW_O = 6,
  parameter int FW_O = 18,
  localparam int OW = 1 + EW_O + FW_O
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [1:0]    rmode_i,
  input logic          valid_o,
  input logic [OW-1:0] z_o,
  input logic [2:0]    class_o,
  input logic          ovf_o,
  input logic          unf_o,
  input logic          inx_o,
  input logic          inv_o
);
  logic [EW_O-1:0] ex;
  logic [FW_O-1:0] fr;
  assign ex = z_o[FW_O +: EW_O];
  assign fr = z_o[FW_O-1:0];

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R13
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R13
  AST_NAN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && class_o == 3'd4) |-> (&ex && fr[FW_O-1])); // R9
  AST_INV_ON_NAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && inv_o) |-> class_o == 3'd4); // R9
  AST_OVF_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ovf_o) |-> inx_o); // R6
  AST_NEAR_OVF_INF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rmode_i == 2'd0) |=> (ovf_o |-> (&ex && fr == '0))); // R6
  AST_UNF_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && unf_o) |-> inx_o); // R7
  AST_ZERO_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && class_o == 3'd0) |-> (ex == '0 && fr == '0 && !ovf_o && !inx_o)); // R10
endmodule

bind fpcvt_top fpcvt_chk #(.EW_O(EW_O), .FW_O(FW_O)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .rmode_i(rmode_i),
  .valid_o(valid_o), .z_o(z_o), .class_o(class_o), .ovf_o(ovf_o),
  .unf_o(unf_o), .inx_o(inx_o), .inv_o(inv_o)
);

// File: tb/fpcvt_top_tb.sv
`timescale 1ns/1ps
module fpcvt_top_tb;
  typedef struct {
    int          sel;
    logic [31:0] z;
    logic [2:0]  cls;
    logic [3:0]  fl;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vin = 1'b0;
  logic [1:0] rm = 2'd0;
  logic [31:0] a_bus = '0;
  always #10 clk = ~clk;

  logic vo_n, vo_w, vo_f;
  logic [24:0] z_n, z_f;
  logic [31:0] z_w;
  logic [2:0] c_n, c_w, c_f;
  logic [3:0] fl_n, fl_w, fl_f;

  fpcvt_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .rmode_i(rm), .a_i(a_bus),
    .valid_o(vo_n), .z_o(z_n), .class_o(c_n),
    .ovf_o(fl_n[2]), .unf_o(fl_n[1]), .inx_o(fl_n[0]), .inv_o(fl_n[3])
  );
  fpcvt_top #(.EW_I(6), .FW_I(18), .EW_O(8), .FW_O(23)) u_wide (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .rmode_i(rm), .a_i(a_bus[24:0]),
    .valid_o(vo_w), .z_o(z_w), .class_o(c_w),
    .ovf_o(fl_w[2]), .unf_o(fl_w[1]), .inx_o(fl_w[0]), .inv_o(fl_w[3])
  );
  fpcvt_top #(.DENORM_EN(1'b0)) u_ftz (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .rmode_i(rm), .a_i(a_bus),
    .valid_o(vo_f), .z_o(z_f), .class_o(c_f),
    .ovf_o(fl_f[2]), .unf_o(fl_f[1]), .inx_o(fl_f[0]), .inv_o(fl_f[3])
  );

  exp_t q[$];
  exp_t it;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [31:0] w8(input logic s, input logic [7:0] e, input logic [22:0] f);
    return {s, e, f};
  endfunction
  function automatic logic [31:0] w6(input logic s, input logic [5:0] e, input logic [17:0] f);
    return {7'b0, s, e, f};
  endfunction

  // sel: 0 narrowing, 1 widening, 2 narrowing with flush-to-zero; flags {inv,ovf,unf,inx}
  task automatic send(input int sel, input logic [31:0] a, input logic [1:0] r,
                      input logic [31:0] ez, input logic [2:0] ec, input logic [3:0] ef,
                      input string tag);
    exp_t e;
    e.sel = sel; e.z = ez; e.cls = ec; e.fl = ef; e.tag = tag;
    a_bus = a; rm = r; vin = 1'b1;
    q.push_back(e);
    @(negedge clk);
    vin = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && vo_n) begin
      logic [31:0] az;
      logic [2:0]  ac;
      logic [3:0]  af;
      n_cmp++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL R13 unexpected result: actual z=%h expected none", z_n);
      end else begin
        it = q.pop_front();
        case (it.sel)
          0:       begin az = {7'b0, z_n}; ac = c_n; af = fl_n; end
          1:       begin az = z_w;         ac = c_w; af = fl_w; end
          default: begin az = {7'b0, z_f}; ac = c_f; af = fl_f; end
        endcase
        if (az !== it.z || ac !== it.cls || af !== it.fl) begin
          n_bad++;
          $display("FAIL %s: actual z=%h cls=%0d fl=%b expected z=%h cls=%0d fl=%b",
                   it.tag, az, ac, af, it.z, it.cls, it.fl);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R13 watchdog: actual no completion expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (vo_n !== 1'b0 || z_n !== '0 || fl_n !== 4'b0) begin
      n_bad++;
      $display("FAIL R13 reset: actual v=%b z=%h expected v=0 z=0", vo_n, z_n);
    end
    // R1 plain conversions
    send(0, w8(0, 127, 23'h0), 0, w6(0, 31, 18'h0), 2, 4'b0000, "R1 one");
    send(0, w8(1, 129, 23'h500000), 0, w6(1, 33, 18'h28000), 2, 4'b0000, "R1 neg 6.5");
    // R3 ties
    send(0, w8(0, 127, 23'h000010), 0, w6(0, 31, 18'h0), 2, 4'b0001, "R3 tie even stays");
    send(0, w8(0, 127, 23'h000030), 0, w6(0, 31, 18'h2), 2, 4'b0001, "R3 tie odd up");
    // R4 directed modes
    send(0, w8(0, 127, 23'h00001F), 1, w6(0, 31, 18'h0), 2, 4'b0001, "R4 toward zero");
    send(0, w8(0, 127, 23'h000001), 2, w6(0, 31, 18'h1), 2, 4'b0001, "R4 up positive");
    send(0, w8(1, 127, 23'h000001), 2, w6(1, 31, 18'h0), 2, 4'b0001, "R4 up negative");
    send(0, w8(1, 127, 23'h000001), 3, w6(1, 31, 18'h1), 2, 4'b0001, "R4 down negative");
    // R5 carry, R12 exact
    send(0, w8(0, 127, 23'h7FFFFF), 0, w6(0, 32, 18'h0), 2, 4'b0001, "R5 carry to exponent");
    send(0, w8(0, 130, 23'h7FFFE0), 0, w6(0, 34, 18'h3FFFF), 2, 4'b0000, "R12 exact no flag");
    // R6 top of range
    send(0, w8(0, 158, 23'h0), 0, w6(0, 62, 18'h0), 2, 4'b0000, "R6 largest exponent fits");
    send(0, w8(0, 159, 23'h0), 0, w6(0, 63, 18'h0), 2, 4'b0101, "R6 nearest to inf");
    send(0, w8(0, 159, 23'h0), 1, w6(0, 62, 18'h3FFFF), 2, 4'b0101, "R6 zero to max");
    send(0, w8(1, 200, 23'h0), 3, w6(1, 63, 18'h0), 2, 4'b0101, "R6 down negative inf");
    send(0, w8(0, 200, 23'h0), 3, w6(0, 62, 18'h3FFFF), 2, 4'b0101, "R6 down positive max");
    send(0, w8(1, 200, 23'h0), 2, w6(1, 62, 18'h3FFFF), 2, 4'b0101, "R6 up negative max");
    send(0, w8(0, 158, 23'h7FFFFF), 0, w6(0, 63, 18'h0), 2, 4'b0101, "R6 rounding overflow");
    // R7 bottom of range
    send(0, w8(0, 96, 23'h0), 0, w6(0, 0, 18'h20000), 2, 4'b0000, "R7 exact denormal");
    send(0, w8(0, 96, 23'h000001), 0, w6(0, 0, 18'h20000), 2, 4'b0011, "R7 inexact denormal");
    send(0, w8(0, 96, 23'h7FFFFF), 0, w6(0, 1, 18'h0), 2, 4'b0011, "R7 round to min normal");
    send(0, w8(0, 1, 23'h0), 0, w6(0, 0, 18'h0), 2, 4'b0011, "R7 below range to zero");
    send(0, w8(0, 1, 23'h0), 2, w6(0, 0, 18'h1), 2, 4'b0011, "R7 below range up");
    send(0, w8(1, 0, 23'h400000), 0, w6(1, 0, 18'h0), 1, 4'b0011, "R2 denormal class");
    // R9, R10 specials
    send(0, w8(1, 0, 23'h0), 0, w6(1, 0, 18'h0), 0, 4'b0000, "R10 negative zero");
    send(0, w8(0, 255, 23'h0), 0, w6(0, 63, 18'h0), 3, 4'b0000, "R10 infinity");
    send(0, w8(1, 255, 23'h000001), 0, w6(1, 63, 18'h20000), 4, 4'b1000, "R9 signalling NaN");
    send(0, w8(0, 255, 23'h400000), 0, w6(0, 63, 18'h20000), 4, 4'b0000, "R9 quiet NaN");
    // R8 widening
    send(1, w6(0, 0, 18'h20000), 0, w8(0, 96, 23'h0), 1, 4'b0000, "R8 denormal top bit");
    send(1, w6(1, 0, 18'h00001), 0, w8(1, 79, 23'h0), 1, 4'b0000, "R8 denormal low bit");
    send(1, w6(0, 0, 18'h00003), 0, w8(0, 80, 23'h400000), 1, 4'b0000, "R8 denormal two bits");
    send(1, w6(0, 31, 18'h0), 0, w8(0, 127, 23'h0), 2, 4'b0000, "R1 widen one");
    send(1, w6(0, 63, 18'h00001), 0, w8(0, 255, 23'h400000), 4, 4'b1000, "R9 widen NaN");
    // R11 flush to zero
    send(2, w8(0, 96, 23'h0), 0, w6(0, 0, 18'h0), 2, 4'b0011, "R11 tiny flush");
    send(2, w8(1, 0, 23'h400000), 0, w6(1, 0, 18'h0), 0, 4'b0000, "R11 denormal input zero");
    send(2, w8(0, 127, 23'h0), 0, w6(0, 31, 18'h0), 2, 4'b0000, "R11 normal unaffected");
    repeat (3) @(negedge clk);
    n_cmp++;
    if (q.size() != 0 || vo_n !== 1'b0) begin
      n_bad++;
      $display("FAIL R13 drain: actual pending=%0d v=%b expected 0 0", q.size(), vo_n);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule